// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

An 8-bit up-counter, advanced by a selectable power-of-two prescaler, drives a single square-wave output. In variable-period mode a period compare value clears the counter on a match, so the wave repeats every (period + 1) × x system clocks, where x is one of 16, 32, 64, 128, 256 or 512. A width compare value decides how long each cycle stays at the active level. In fixed-period mode the counter runs freely from 0 to 255 and wraps, which gives plain PWM with a period of 256 × x.

Software programs both compare values and one control byte through a simple write port. Each compare match sends a one-cycle strobe, so software can rewrite a compare value at a safe point. The active phase starts on the prescaled edge that brings the counter to 0. It ends two system clocks after the prescaled edge that brings the counter to the width value. This makes the active part 2 clocks longer than width × x, and the inactive part 2 clocks shorter than its ideal length. When the output is disabled, the pin holds the inactive level for the selected polarity.

Top module: `ppg_timer`

## Requirements
- R1: A synchronous reset clears the counter, the prescaler, both compare values and the control byte. After reset the pin is 1 (the inverse of a cleared active-level bit) and both strobes are 0.
- R2: Writes use `wrAddr` as follows. Address 0 loads the width compare, address 1 loads the period compare, and address 2 loads the control byte. A write to address 3 has no effect.
- R3: The control byte bits [2:0] select x = 16 << sel for sel 0..5. Values 6 and 7 select 512. The counter changes only once every x system clocks.
- R4: Variable-period mode is control bit 7 = 1. With clear-on-period (bit 5) set, the counter holds the period value for x clocks and then goes to 0. The pin period is (period + 1) × x clocks.
- R5: The pin goes active on the clock after the prescaled edge that makes the counter 0. It goes inactive two clocks after the prescaled edge that makes the counter equal the width value. The active time is width × x + 2 clocks.
- R6: Fixed-period mode is bit 7 = 0. The counter wraps from 255 to 0, the period is 256 × x, and bits 5 and 6 are ignored.
- R7: A width value written below the current count while the pin is active keeps the pin active through the wrap. The pin stays active until the counter next reaches the new value (100% duty meanwhile).
- R8: Bit 3 is the active level (1 = high). Bit 4 enables the output. With bit 4 = 0 the pin always shows the inverse of bit 3.
- R9: `irqWidth` (or `irqPeriod`) is a one-cycle pulse in the cycle after a prescaled edge brings the counter to the width (or period) value.
- R10: In variable-period mode with clear-on-width (bit 6) set, a width match also clears the counter. The period is then (width + 1) × x.
- R11: After reset the pin stays inactive until a prescaled edge first brings the counter back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 width, 1 period, 2 control |
| wrData | input | 8 | Write data |
| timerOut | output | 1 | Pulse output pin |
| irqWidth | output | 1 | Width compare match strobe |
| irqPeriod | output | 1 | Period compare match strobe |

## Verification
A register write takes effect at the clock edge that samples it. A prescaled counting edge shows up in the next cycle: the counter moves, either strobe may pulse, and the pin may turn active. A pin that is due to go inactive does so two cycles after the strobe. The bench's reference model advances its state on each rising edge, using its own cycle count since reset to place the prescaled edges and a queue of due times for the stretched deactivation. It compares all three outputs on every falling edge. Directed checks time the pin's active and full periods between observed edges and compare them with the formulas in the requirements.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  // Control byte layout, most significant field first.
  typedef struct packed {
    logic       varPeriod;    // 1: counter cleared by compare, 0: free wrap
    logic       clrOnWidth;   // clear counter on width match (variable mode)
    logic       clrOnPeriod;  // clear counter on period match (variable mode)
    logic       outEnable;    // drive the pulse onto the pin
    logic       activeHigh;   // level of the active phase
    logic [2:0] preSel;       // prescaler step
  } cfg_t;

  // Strobes from control to the datapath counter.
  typedef struct packed {
    logic advance;
    logic clear;
  } cnt_strobe_t;

  // Comparator results from the datapath, all from the current count.
  typedef struct packed {
    logic eqWidth;
    logic eqPeriod;
    logic atMax;
    logic preWidth;
    logic prePeriod;
    logic widthZero;
    logic periodZero;
  } cnt_flags_t;

  localparam logic [1:0] ADDR_WIDTH  = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

endpackage

// File: rtl/ppg_datapath.sv
module ppg_datapath
  import ppg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  cnt_strobe_t       strobe,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cmpWidth,
  output logic [CNT_W-1:0]  cmpPeriod,
  output cnt_flags_t        flags
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countInc;

  // Register bank
  always_ff @(posedge clk) begin
    if (rst) begin
      cmpWidth  <= '0;
      cmpPeriod <= '0;
      cfg       <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_WIDTH:  cmpWidth  <= wrData;
        ADDR_PERIOD: cmpPeriod <= wrData;
        ADDR_CTRL:   cfg       <= cfg_t'(wrData[7:0]);
        default: ;
      endcase
    end
  end

  assign countInc = count + ONE;

  // Up-counter, moved only by the control strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strobe.advance) begin
      count <= strobe.clear ? '0 : countInc;
    end
  end

  // Comparators against current and next count
  always_comb begin
    flags.eqWidth    = (count == cmpWidth);
    flags.eqPeriod   = (count == cmpPeriod);
    flags.atMax      = &count;
    flags.preWidth   = (countInc == cmpWidth);
    flags.prePeriod  = (countInc == cmpPeriod);
    flags.widthZero  = (cmpWidth == '0);
    flags.periodZero = (cmpPeriod == '0);
  end

endmodule

// File: rtl/ppg_control.sv
module ppg_control
  import ppg_pkg::*;
#(
  parameter int PRE_BASE_LOG = 4,
  parameter int PRE_STEPS    = 6,
  parameter int STRETCH      = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  cfg_t        cfg,
  input  cnt_flags_t  flags,
  output cnt_strobe_t strobe,
  output logic        tick,
  output logic        actState,
  output logic        timerOut,
  output logic        irqWidth,
  output logic        irqPeriod
);

  localparam int PRE_W   = PRE_BASE_LOG + PRE_STEPS - 1;
  localparam int SEL_MAX = PRE_STEPS - 1;

  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   tickMask;
  logic [2:0]         selClamped;
  logic [STRETCH-1:0] hitLine;
  logic               nextZero;
  logic               nextEqW;
  logic               nextEqP;
  logic               newHit;
  logic               irqPeriodQ;

  // Free-running prescaler; a step's tick fires when its low bits are all ones
  always_ff @(posedge clk) begin
    if (rst) preCnt <= '0;
    else     preCnt <= preCnt + PRE_W'(1);
  end

  assign selClamped = (cfg.preSel > 3'(SEL_MAX)) ? 3'(SEL_MAX) : cfg.preSel;

  always_comb begin
    tickMask = '0;
    for (int s = 0; s < PRE_STEPS; s++) begin
      if (int'(selClamped) == s) tickMask = PRE_W'((1 << (PRE_BASE_LOG + s)) - 1);
    end
  end

  assign tick = ((preCnt & tickMask) == tickMask);

  // Counter strobes
  always_comb begin
    strobe.advance = tick;
    strobe.clear   = tick & cfg.varPeriod &
                     ((cfg.clrOnPeriod & flags.eqPeriod) | (cfg.clrOnWidth & flags.eqWidth));
  end

  // Where the counter lands on this edge
  assign nextZero = strobe.clear | flags.atMax;
  assign nextEqW  = strobe.clear ? flags.widthZero  : flags.preWidth;
  assign nextEqP  = strobe.clear ? flags.periodZero : flags.prePeriod;
  assign newHit   = tick & nextEqW;

  // Deactivation delay line
  generate
    if (STRETCH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hitLine <= '0;
        else     hitLine <= newHit;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) hitLine <= '0;
        else     hitLine <= {hitLine[STRETCH-2:0], newHit};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irqPeriodQ <= 1'b0;
    else     irqPeriodQ <= tick & nextEqP;
  end

  // Active phase: set on reaching zero, cleared at the end of the delay line
  always_ff @(posedge clk) begin
    if (rst)                   actState <= 1'b0;
    else if (tick & nextZero)  actState <= 1'b1;
    else if (hitLine[STRETCH-1]) actState <= 1'b0;
  end

  assign irqWidth  = hitLine[0];
  assign irqPeriod = irqPeriodQ;
  assign timerOut  = (cfg.outEnable & actState) ? cfg.activeHigh : ~cfg.activeHigh;

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int PRE_BASE_LOG = 4,
  parameter int PRE_STEPS    = 6,
  parameter int STRETCH      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             timerOut,
  output logic             irqWidth,
  output logic             irqPeriod
);

  cfg_t             cfg;
  cnt_strobe_t      strobe;
  cnt_flags_t       flags;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmpWidth;
  logic [CNT_W-1:0] cmpPeriod;
  logic             tick;
  logic             actState;

  ppg_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .cfg(cfg), .count(count), .cmpWidth(cmpWidth),
    .cmpPeriod(cmpPeriod), .flags(flags)
  );

  ppg_control #(
    .PRE_BASE_LOG(PRE_BASE_LOG), .PRE_STEPS(PRE_STEPS), .STRETCH(STRETCH)
  ) u_ctl (
    .clk(clk), .rst(rst), .cfg(cfg), .flags(flags), .strobe(strobe),
    .tick(tick), .actState(actState), .timerOut(timerOut),
    .irqWidth(irqWidth), .irqPeriod(irqPeriod)
  );

endmodule

// File: rtl/ppg_timer_chk.sv
module ppg_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             timerOut,
  input logic             irqWidth,
  input logic             irqPeriod,
  input logic             tick,
  input logic             actState,
  input logic             varPeriod,
  input logic             clrOnPeriod,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmpWidth,
  input logic [CNT_W-1:0] cmpPeriod
);

  // R1: first cycle out of reset shows the idle state
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (timerOut && !irqWidth && !irqPeriod && count == '0));

  // R3: counter moves only on a prescaler tick
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  // R4: period match clears the counter in variable mode
  assert_period_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && varPeriod && clrOnPeriod && count == cmpPeriod) |=> (count == '0));

  // R5: active phase ends two cycles after the width strobe
  assert_stretch_R5: assert property (@(posedge clk) disable iff (rst)
    irqWidth |-> ##2 !actState);

  // R6: free mode wraps at the top
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !varPeriod && (&count)) |=> (count == '0));

  // R9: strobes flag the count that was just reached and last one cycle
  assert_irq_width_R9: assert property (@(posedge clk) disable iff (rst)
    irqWidth |-> (count == $past(cmpWidth)));

  assert_irq_period_R9: assert property (@(posedge clk) disable iff (rst)
    irqPeriod |-> (count == $past(cmpPeriod)));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
    irqWidth |=> !irqWidth);

endmodule

bind ppg_timer ppg_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .timerOut(timerOut), .irqWidth(irqWidth),
  .irqPeriod(irqPeriod), .tick(tick), .actState(actState),
  .varPeriod(cfg.varPeriod), .clrOnPeriod(cfg.clrOnPeriod),
  .count(count), .cmpWidth(cmpWidth), .cmpPeriod(cmpPeriod)
);

// File: tb/tb_ppg_timer.sv
`timescale 1ns/1ps
module tb_ppg_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       timerOut, irqWidth, irqPeriod;

  ppg_timer dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerOut(timerOut), .irqWidth(irqWidth), .irqPeriod(irqPeriod)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", curReq, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int  mW, mP, mSel, mCnt, mCyc, mX, mNext;
  bit  mAlv, mEn, mClrP, mClrW, mVar, mAct, mIrqW, mIrqP, mTick, mClr;
  int  dueQ[$];

  always @(posedge clk) begin
    if (rst) begin
      mW = 0; mP = 0; mSel = 0; mCnt = 0; mCyc = 0;
      mAlv = 0; mEn = 0; mClrP = 0; mClrW = 0; mVar = 0;
      mAct = 0; mIrqW = 0; mIrqP = 0;
      dueQ.delete();
    end else begin
      mX = 16 << ((mSel > 5) ? 5 : mSel);
      mTick = ((mCyc % mX) == mX - 1);
      mIrqW = 0; mIrqP = 0;
      if (dueQ.size() > 0 && dueQ[0] == mCyc) begin
        void'(dueQ.pop_front());
        mAct = 0;
      end
      if (mTick) begin
        mClr = mVar && ((mClrP && mCnt == mP) || (mClrW && mCnt == mW));
        mNext = mClr ? 0 : (mCnt + 1) % 256;
        if (mNext == 0) mAct = 1;
        if (mNext == mW) begin mIrqW = 1; dueQ.push_back(mCyc + 2); end
        if (mNext == mP) mIrqP = 1;
        mCnt = mNext;
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: mW = int'(wrData);
          2'd1: mP = int'(wrData);
          2'd2: begin
            mSel = int'(wrData[2:0]); mAlv = wrData[3]; mEn = wrData[4];
            mClrP = wrData[5]; mClrW = wrData[6]; mVar = wrData[7];
          end
          default: ;
        endcase
      end
      mCyc++;
    end
  end

  // Every-cycle comparison against the model
  bit expPin;
  always @(negedge clk) begin
    if (!rst) begin
      expPin = mEn ? (mAct ? mAlv : !mAlv) : !mAlv;
      chk(timerOut === expPin, "pin vs model", int'(timerOut), int'(expPin));
      chk(irqWidth === mIrqW, "irqWidth vs model", int'(irqWidth), int'(mIrqW));
      chk(irqPeriod === mIrqP, "irqPeriod vs model", int'(irqPeriod), int'(mIrqP));
    end
  end

  // ---------------- helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Times one active phase and the full period, starting at an active edge.
  task automatic measure(input logic actv, output int hi, output int per);
    logic prev;
    prev = timerOut;
    forever begin
      @(negedge clk);
      if (timerOut == actv && prev != actv) break;
      prev = timerOut;
    end
    hi = 0;
    do begin @(negedge clk); hi++; end while (timerOut == actv);
    per = hi;
    do begin @(negedge clk); per++; end while (timerOut != actv);
  endtask

  task automatic measure2(input logic actv, output int hi, output int per);
    measure(actv, hi, per);
    measure(actv, hi, per);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL %s watchdog expired actual=%0d expected=%0d", curReq, 1, 0);
    finishRun();
  end

  // ---------------- directed sequence ----------------
  initial begin
    int hi, per, bad, nW, nP;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    curReq = "R1";
    chk(timerOut == 1'b1, "reset pin level", int'(timerOut), 1);
    chk(irqWidth == 1'b0 && irqPeriod == 1'b0, "reset strobes", int'(irqWidth | irqPeriod), 0);

    // Variable period, x=16, width 3, period 9, active high
    curReq = "R11";
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd9);
    wr(2'd2, 8'hB8);
    @(negedge clk);
    chk(timerOut == 1'b0, "inactive before first zero", int'(timerOut), 0);
    curReq = "R4";
    measure2(1'b1, hi, per);
    chk(per == 160, "period (9+1)*16", per, 160);
    curReq = "R5";
    chk(hi == 50, "active 3*16+2", hi, 50);

    // Address 3 must not touch anything
    curReq = "R2";
    wr(2'd3, 8'h00);
    measure2(1'b1, hi, per);
    chk(per == 160, "period after addr3 write", per, 160);
    chk(hi == 50, "active after addr3 write", hi, 50);

    // Strobe counts over exactly ten periods
    curReq = "R9";
    nW = 0; nP = 0;
    repeat (1600) begin
      @(negedge clk);
      if (irqWidth) nW++;
      if (irqPeriod) nP++;
    end
    chk(nW == 10, "irqWidth pulses in 1600 cycles", nW, 10);
    chk(nP == 10, "irqPeriod pulses in 1600 cycles", nP, 10);

    // Prescaler x=64
    curReq = "R3";
    wr(2'd0, 8'd2);
    wr(2'd1, 8'd4);
    wr(2'd2, 8'hBA);
    measure2(1'b1, hi, per);
    chk(per == 320, "period x=64", per, 320);
    chk(hi == 130, "active x=64", hi, 130);

    // Select 7 clamps to 512, width 0 gives a two-clock pulse
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd1);
    wr(2'd2, 8'hBF);
    measure2(1'b1, hi, per);
    chk(per == 1024, "period sel7 x=512", per, 1024);
    curReq = "R5";
    chk(hi == 2, "active width 0", hi, 2);

    // Active low polarity
    curReq = "R8";
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd9);
    wr(2'd2, 8'hB0);
    measure2(1'b0, hi, per);
    chk(hi == 50, "active-low pulse", hi, 50);
    chk(per == 160, "active-low period", per, 160);

    // Output disabled: pin fixed at inverse of active-high bit (0)
    wr(2'd2, 8'hA8);
    bad = 0;
    repeat (400) begin
      @(negedge clk);
      if (timerOut != 1'b0) bad++;
    end
    chk(bad == 0, "disabled pin not at inactive level", bad, 0);

    // Clear on width match
    curReq = "R10";
    wr(2'd0, 8'd5);
    wr(2'd1, 8'd200);
    wr(2'd2, 8'hD8);
    measure2(1'b1, hi, per);
    chk(per == 96, "period (5+1)*16", per, 96);
    chk(hi == 82, "active 5*16+2", hi, 82);

    // Fixed-period mode, clear bit set but ignored
    curReq = "R6";
    wr(2'd0, 8'd20);
    wr(2'd2, 8'h38);
    measure2(1'b1, hi, per);
    chk(per == 4096, "fixed period 256*16", per, 4096);
    chk(hi == 322, "fixed active 20*16+2", hi, 322);

    // Width rewritten below the running count while active
    curReq = "R7";
    wr(2'd0, 8'd100);
    while (!(mCnt == 50 && timerOut == 1'b1)) @(negedge clk);
    wr(2'd0, 8'd10);
    bad = 0;
    repeat (3000) begin
      @(negedge clk);
      if (timerOut != 1'b1) bad++;
    end
    chk(bad == 0, "inactive cycles during forced full duty", bad, 0);
    measure2(1'b1, hi, per);
    chk(hi == 162, "active after wrap with new width", hi, 162);

    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule